// File: doc/BRIEF.md
# Integer Status Flag Evaluator

This block works out the integer status flags that follow an ALU operation and keeps them in a small flag register. For each operation it receives the first source operand, an optional second source operand, an optional immediate and the ALU result. It then derives carry at full width and at half width, signed overflow at both widths, a sticky summary-overflow bit and a four-bit condition field. Each flag group has its own enable. A mask can hold back a carry flag that the operation has already written by other means. A divide unit can supply its own overflow verdict, which takes the place of the sign rule.

Operations arrive as single-beat transfers on a valid/ready pair. Ready is high whenever reset is released and there is no back-pressure, so every cycle with valid high is one accepted operation. The flag register changes on the clock edge that accepts the operation. Its outputs show the new flags from the next cycle on. While valid is low, or while in reset, no flag changes.

Top module: `cflags_top`

## Requirements
- R1: When `inv_a` is set, the first operand is replaced by its bitwise complement before any flag is evaluated. When `imm_ok` is set, `imm` takes part as an extra operand in the carry comparison.
- R2: The new carry `ca` is 1 exactly when some present operand (complemented first operand, `src_b` if `has_b`, `imm` if `imm_ok`) is unsigned-greater than the full-width result.
- R3: When `is_add` is set, the new half carry `ca32` is bit W/2 of the result XOR bit W/2 of the first operand XOR bit W/2 of the second operand. The second operand is `src_b` if present, else `imm` if valid, else zero.
- R4: When `is_add` is clear, the new `ca32` is 1 exactly when the low W/2 bits of some present operand are unsigned-greater than the low W/2 bits of the result.
- R5: `done_mask` bit 0 keeps `ca` unchanged and bit 1 keeps `ca32` unchanged for that operation.
- R6: Neither carry flag changes unless `carry_en` is set.
- R7: Without a divide verdict, when at least two operands are present, the new `ov` is 1 when the first and second operands have the same top bit and the result top bit differs from it. The new `ov32` applies the same rule to bit W/2-1.
- R8: When `div_ov_vld` is set, both `ov` and `ov32` take the value of `div_ov`. With fewer than two operands and no divide verdict, `ov`, `ov32` and `so` are unchanged.
- R9: `ov`, `ov32` and `so` change only when both `ov_en` and `ov_ok` are set.
- R10: `so` is sticky: on each overflow update it becomes its old value OR the new `ov`, and it never falls outside reset.
- R11: When `rc_en` is set, `cr` becomes {negative, positive, zero, so} of the signed result, with negative in bit 3 and using the `so` value written by the same operation. Otherwise `cr` is unchanged.
- R12: Reset clears every flag and `cr` to zero. Out of reset `op_ready` is 1, and no flag changes in a cycle without `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation beat valid |
| op_ready | output | 1 | Operation beat accepted (high out of reset) |
| src_a | input | W | First source operand |
| inv_a | input | 1 | Complement the first operand |
| src_b | input | W | Second source operand |
| has_b | input | 1 | Second operand present |
| imm | input | W | Immediate operand |
| imm_ok | input | 1 | Immediate present |
| res | input | W | ALU result |
| is_add | input | 1 | Operation is an addition (half-carry rule) |
| carry_en | input | 1 | Update carry flags |
| ov_en | input | 1 | Overflow update requested |
| ov_ok | input | 1 | Overflow request qualifier |
| rc_en | input | 1 | Update condition field |
| div_ov_vld | input | 1 | Divide overflow verdict supplied |
| div_ov | input | 1 | Divide overflow verdict |
| done_mask | input | 2 | Bit 0 holds `ca`, bit 1 holds `ca32` |
| ca | output | 1 | Carry flag |
| ca32 | output | 1 | Half-width carry flag |
| ov | output | 1 | Overflow flag |
| ov32 | output | 1 | Half-width overflow flag |
| so | output | 1 | Sticky summary overflow |
| cr | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The bench uses an 8-bit configuration. It sweeps grids of operand pairs with results formed in three ways: as sums, which exercise the add half-carry and signed overflow; as complemented-operand differences with the add rule off, which tell the half-width comparison apart from the XOR rule; and with an immediate in place of the second operand. Further runs set each mask bit and clear each enable and qualifier, and then confirm that the held flags keep their earlier values at the outputs. Single-operand and divide-verdict operations separate the bypass from the "unchanged" case. Runs of non-overflowing operations after an overflow show that `so` stays set.

// File: rtl/cflags_pkg.sv
package cflags_pkg;
  localparam int unsigned CR_W = 4;
  localparam int unsigned NSLOT = 3;

  typedef struct packed {
    logic            ca;
    logic            ca32;
    logic            ov;
    logic            ov32;
    logic            so;
    logic [CR_W-1:0] cr;
  } flag_state_t;
endpackage

// File: rtl/cflags_carry.sv
module cflags_carry #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         has_b,
  input  logic [W-1:0] imm,
  input  logic         imm_ok,
  input  logic [W-1:0] res,
  input  logic         is_add,
  output logic         ca_new,
  output logic         ca32_new
);
  import cflags_pkg::*;
  localparam int unsigned H = W / 2;

  logic [W-1:0]     slot_val [NSLOT];
  logic [NSLOT-1:0] slot_on;
  logic [NSLOT-1:0] gt_full;
  logic [NSLOT-1:0] gt_half;
  logic [W-1:0]     second;

  always_comb begin
    slot_val[0] = opa;  slot_on[0] = 1'b1;
    slot_val[1] = opb;  slot_on[1] = has_b;
    slot_val[2] = imm;  slot_on[2] = imm_ok;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign gt_full[g] = slot_on[g] && (slot_val[g] > res);
    assign gt_half[g] = slot_on[g] && (slot_val[g][H-1:0] > res[H-1:0]);
  end

  assign second   = has_b ? opb : (imm_ok ? imm : '0);
  assign ca_new   = |gt_full;
  assign ca32_new = is_add ? (res[H] ^ opa[H] ^ second[H]) : (|gt_half);
endmodule

// File: rtl/cflags_ovf.sv
module cflags_ovf #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] second,
  input  logic         two_ops,
  input  logic [W-1:0] res,
  input  logic         div_ov_vld,
  input  logic         div_ov,
  output logic         ov_new,
  output logic         ov32_new,
  output logic         ov_have
);
  localparam int unsigned H = W / 2;

  logic sgn_full, sgn_half;
  assign sgn_full = (opa[W-1] == second[W-1]) && (res[W-1] != opa[W-1]);
  assign sgn_half = (opa[H-1] == second[H-1]) && (res[H-1] != opa[H-1]);

  always_comb begin
    ov_have  = div_ov_vld || two_ops;
    ov_new   = div_ov_vld ? div_ov : sgn_full;
    ov32_new = div_ov_vld ? div_ov : sgn_half;
  end
endmodule

// File: rtl/cflags_cond.sv
module cflags_cond #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] res,
  input  logic         so_in,
  output logic [3:0]   cr_new
);
  logic neg, zer;
  assign neg    = res[W-1];
  assign zer    = (res == '0);
  assign cr_new = {neg, !neg && !zer, zer, so_in};
endmodule

// File: rtl/cflags_top.sv
module cflags_top #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [W-1:0] src_a,
  input  logic         inv_a,
  input  logic [W-1:0] src_b,
  input  logic         has_b,
  input  logic [W-1:0] imm,
  input  logic         imm_ok,
  input  logic [W-1:0] res,
  input  logic         is_add,
  input  logic         carry_en,
  input  logic         ov_en,
  input  logic         ov_ok,
  input  logic         rc_en,
  input  logic         div_ov_vld,
  input  logic         div_ov,
  input  logic [1:0]   done_mask,
  output logic         ca,
  output logic         ca32,
  output logic         ov,
  output logic         ov32,
  output logic         so,
  output logic [3:0]   cr
);
  import cflags_pkg::*;

  flag_state_t  st_q, st_d;
  logic [W-1:0] opa, second;
  logic         acc, ca_new, ca32_new, ov_new, ov32_new, ov_have;
  logic         ov_wr, so_next;
  logic [3:0]   cr_new;

  assign op_ready = rst_n;
  assign acc      = op_valid && op_ready;
  assign opa      = inv_a ? ~src_a : src_a;
  assign second   = has_b ? src_b : (imm_ok ? imm : '0);

  cflags_carry #(.W(W)) u_carry (
    .opa(opa), .opb(src_b), .has_b(has_b), .imm(imm), .imm_ok(imm_ok),
    .res(res), .is_add(is_add), .ca_new(ca_new), .ca32_new(ca32_new)
  );

  cflags_ovf #(.W(W)) u_ovf (
    .opa(opa), .second(second), .two_ops(has_b || imm_ok), .res(res),
    .div_ov_vld(div_ov_vld), .div_ov(div_ov),
    .ov_new(ov_new), .ov32_new(ov32_new), .ov_have(ov_have)
  );

  assign ov_wr   = acc && ov_en && ov_ok && ov_have;
  assign so_next = ov_wr ? (st_q.so | ov_new) : st_q.so;

  cflags_cond #(.W(W)) u_cond (.res(res), .so_in(so_next), .cr_new(cr_new));

  always_comb begin
    st_d = st_q;
    if (acc && carry_en && !done_mask[0]) st_d.ca   = ca_new;
    if (acc && carry_en && !done_mask[1]) st_d.ca32 = ca32_new;
    if (ov_wr) begin
      st_d.ov   = ov_new;
      st_d.ov32 = ov32_new;
    end
    st_d.so = so_next;
    if (acc && rc_en) st_d.cr = cr_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign ca   = st_q.ca;
  assign ca32 = st_q.ca32;
  assign ov   = st_q.ov;
  assign ov32 = st_q.ov32;
  assign so   = st_q.so;
  assign cr   = st_q.cr;

  // R10
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so |=> so);

  // R5
  ca_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && done_mask[0]) |=> $stable(ca));

  // R9
  ov_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(op_valid && ov_en && ov_ok)) |=> ($stable(ov) && $stable(ov32) && $stable(so)));

  // R8
  div_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ov_en && ov_ok && div_ov_vld) |=> (ov == $past(div_ov) && ov32 == ov));

  // R11
  cr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cr[3:1]));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(ca) && $stable(ca32) && $stable(cr)));
endmodule

// File: tb/cflags_top_bench.sv
module cflags_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, inv_a = 1'b0, has_b = 1'b0, imm_ok = 1'b0, is_add = 1'b0;
  logic carry_en = 1'b0, ov_en = 1'b0, ov_ok = 1'b0, rc_en = 1'b0, div_ov_vld = 1'b0, div_ov = 1'b0;
  logic [W-1:0] src_a = '0, src_b = '0, imm = '0, res = '0;
  logic [1:0] done_mask = '0;
  logic op_ready, ca, ca32, ov, ov32, so;
  logic [3:0] cr;

  int n_tests = 0, n_fail = 0;
  bit e_ca, e_ca32, e_ov, e_ov32, e_so;
  bit [3:0] e_cr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cflags_top #(.W(W)) u_cflags_top (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .src_a(src_a), .inv_a(inv_a), .src_b(src_b), .has_b(has_b), .imm(imm),
    .imm_ok(imm_ok), .res(res), .is_add(is_add), .carry_en(carry_en),
    .ov_en(ov_en), .ov_ok(ov_ok), .rc_en(rc_en), .div_ov_vld(div_ov_vld),
    .div_ov(div_ov), .done_mask(done_mask), .ca(ca), .ca32(ca32), .ov(ov),
    .ov32(ov32), .so(so), .cr(cr)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string scen, input bit add_mode);
    chk({scen, " R2 ca"}, {3'b0, ca}, {3'b0, e_ca});
    chk({scen, add_mode ? " R3 ca32" : " R4 ca32"}, {3'b0, ca32}, {3'b0, e_ca32});
    chk({scen, " R7 ov"}, {3'b0, ov}, {3'b0, e_ov});
    chk({scen, " R7 ov32"}, {3'b0, ov32}, {3'b0, e_ov32});
    chk({scen, " R10 so"}, {3'b0, so}, {3'b0, e_so});
    chk({scen, " R11 cr"}, cr, e_cr);
  endtask

  task automatic run_op(input string scen, input bit [7:0] a, b, r, im,
                        input bit ia, hb, io, add, cen, oen, ook, rc, dvv, dv,
                        input bit [1:0] m);
    bit [7:0] oa, sec;
    bit nca, nca32, nov, nov32;
    @(negedge clk);
    src_a = a; src_b = b; res = r; imm = im; inv_a = ia; has_b = hb; imm_ok = io;
    is_add = add; carry_en = cen; ov_en = oen; ov_ok = ook; rc_en = rc;
    div_ov_vld = dvv; div_ov = dv; done_mask = m; op_valid = 1'b1;
    oa  = ia ? ~a : a;
    sec = hb ? b : (io ? im : 8'd0);
    nca = (oa > r) || (hb && b > r) || (io && im > r);
    if (add) nca32 = r[4] ^ oa[4] ^ sec[4];
    else nca32 = (oa[3:0] > r[3:0]) || (hb && b[3:0] > r[3:0]) || (io && im[3:0] > r[3:0]);
    if (cen && !m[0]) e_ca = nca;
    if (cen && !m[1]) e_ca32 = nca32;
    if (oen && ook && (dvv || hb || io)) begin
      if (dvv) begin nov = dv; nov32 = dv; end
      else begin
        nov   = (oa[7] == sec[7]) && (r[7] != oa[7]);
        nov32 = (oa[3] == sec[3]) && (r[3] != oa[3]);
      end
      e_ov = nov; e_ov32 = nov32; e_so = e_so | nov;
    end
    if (rc) e_cr = {$signed(r) < 0, $signed(r) > 0, r == 8'd0, e_so};
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk_all(scen, add);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset flags", {ca, ca32, ov, ov32}, 4'h0);
    chk("R12 reset so", {3'b0, so}, 4'h0);
    chk("R12 reset cr", cr, 4'h0);
    chk("R12 ready in reset", {3'b0, op_ready}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready", {3'b0, op_ready}, 4'h1);

    // sums: add half-carry and signed overflow
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 13)
        run_op("add", 8'(a), 8'(b), 8'(a + b), 8'd0, 0, 1, 0, 1, 1, 1, 1, 1, 0, 0, 2'b00);
    // complemented first operand, comparison half carry (R1)
    for (int a = 0; a < 256; a += 9)
      for (int b = 0; b < 256; b += 11)
        run_op("R1 inv", 8'(a), 8'(b), 8'(b - a), 8'd0, 1, 1, 0, 0, 1, 1, 1, 1, 0, 0, 2'b00);
    // immediate as second operand (R1)
    for (int a = 0; a < 256; a += 5)
      for (int i = 0; i < 256; i += 17)
        run_op("R1 imm", 8'(a), 8'hff, 8'(a + i), 8'(i), 0, 0, 1, 1, 1, 1, 1, 1, 0, 0, 2'b00);
    // mask bits hold carries (R5)
    for (int k = 0; k < 64; k++)
      run_op("R5 mask", 8'(k * 37), 8'(k * 91), 8'(k * 53), 8'd0, 0, 1, 0, k[0], 1, 1, 1, 1, 0, 0, 2'(k >> 1));
    // carry enable off (R6)
    for (int k = 0; k < 32; k++)
      run_op("R6 cen off", 8'(k * 29), 8'(k * 71), 8'(k * 3), 8'd0, 0, 1, 0, 1, 0, 1, 1, 1, 0, 0, 2'b00);
    // overflow gating (R9)
    for (int k = 0; k < 32; k++)
      run_op("R9 gate", 8'h70 + 8'(k), 8'h70, 8'h90 + 8'(k), 8'd0, 0, 1, 0, 1, 1, k[0], k[1], k[2], 0, 0, 2'b00);
    // single operand: overflow unchanged (R8)
    run_op("R8 set", 8'h7f, 8'h01, 8'h80, 8'd0, 0, 1, 0, 1, 1, 1, 1, 1, 0, 0, 2'b00);
    for (int k = 0; k < 16; k++)
      run_op("R8 single", 8'(k * 19), 8'd0, 8'(k * 5), 8'd0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 2'b00);
    // divide verdict bypass (R8) and stickiness (R10)
    for (int k = 0; k < 16; k++)
      run_op("R8 div", 8'h7f, 8'h01, 8'h80, 8'd0, 0, k[2], 0, 0, 1, 1, 1, 1, 1, k[0], 2'b00);
    for (int k = 0; k < 16; k++)
      run_op("R10 sticky", 8'(k), 8'(k), 8'(2 * k), 8'd0, 0, 1, 0, 1, 1, 1, 1, 1, 0, 0, 2'b00);
    // idle cycles leave flags alone (R12)
    repeat (4) @(negedge clk);
    chk_all("R12 idle", 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule